// File: doc/BRIEF.md
# Receive Frame Acceptance and Status Unit

This unit sits behind the preamble/start-delimiter stripper of an Ethernet receive path. It consumes the frame bytes one per valid strobe, starting with the first destination-address byte. It decides whether the receive FIFO keeps or discards the frame, and reports a packed status word once the frame ends.

The destination address is checked against a programmed station address and against the broadcast, multicast and promiscuous settings. An address failure rejects the frame at once. A passing frame is not committed until 64 bytes have arrived, so collision fragments never reach the FIFO as accepted data. Frames longer than the programmed limit are passed through whole. They are marked over-length and can raise a babbling-receiver interrupt. A frame-received interrupt follows each status word when its mask bit is set.

Top module: `rxf_accept_status`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is zero.
- R2: A frame passes address checking when any of these holds: its 6 destination bytes equal `station_addr`, with byte 0 taken from bits [47:40]; it is broadcast and `bc_reject` is low; it is multicast and `mc_enable` is high; or `promisc` is high.
- R3: A frame whose address fails gets a one-cycle `fifo_reject` pulse in the cycle after its 6th byte is presented.
- R4: A frame whose address passes and that reaches 64 bytes gets a one-cycle `fifo_accept` pulse in the cycle after its 64th byte. Each frame receives exactly one accept or one reject, never both.
- R5: A frame that ends before 64 bytes, and was not already rejected for its address, gets `fifo_reject` in the cycle after its last byte. This includes frames shorter than 6 bytes.
- R6: In the cycle after the last byte, `stat_vld` pulses and `stat_word` holds the following: [31] M, [30] BC, [29] MC, [28] LG, [27] NO, [26] CR, [25] OV, [24] TR, [23:11] zero, and [10:0] the frame length in bytes.
- R7: BC is set when all 6 destination bytes are 8'hFF. MC is set when bit 0 of destination byte 0 is one and the frame is not broadcast. Both flags are zero for frames shorter than 6 bytes.
- R8: M is set only when `promisc` let through a frame that no other rule in R2 passes.
- R9: LG is set when the length exceeds `max_len`. The frame is still counted and accepted in full. `babble_irq` pulses once per frame, in the cycle after the first byte that takes the count past `max_len`, and only if `babble_irq_en` is high.
- R10: NO, CR, OV and TR copy `in_dribble`, `in_crc_err`, `in_overrun` and `in_trunc` as sampled with the last byte.
- R11: `frame_irq` pulses together with `stat_vld` when `frame_irq_en` is high, and stays low otherwise.
- R12: The length field saturates at 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Frame byte strobe |
| in_byte | input | 8 | Frame byte, destination address first |
| in_last | input | 1 | Marks the final byte of the frame |
| in_dribble | input | 1 | Extra bits past the final byte (sampled with in_last) |
| in_crc_err | input | 1 | CRC failure (sampled with in_last) |
| in_overrun | input | 1 | FIFO overrun (sampled with in_last) |
| in_trunc | input | 1 | Abnormal end of data valid (sampled with in_last) |
| station_addr | input | 48 | Station address, byte 0 in [47:40] |
| max_len | input | 11 | Maximum frame length in bytes |
| promisc | input | 1 | Pass every frame |
| mc_enable | input | 1 | Pass multicast frames |
| bc_reject | input | 1 | Refuse broadcast frames |
| babble_irq_en | input | 1 | Mask for babble_irq |
| frame_irq_en | input | 1 | Mask for frame_irq |
| fifo_accept | output | 1 | Keep the current frame |
| fifo_reject | output | 1 | Discard the current frame |
| stat_vld | output | 1 | Status word valid |
| stat_word | output | 32 | Frame status word |
| babble_irq | output | 1 | Over-length interrupt |
| frame_irq | output | 1 | Frame-received interrupt |

## Verification
The checks assume that every configuration input (address, masks, rule enables, length limit) is held constant while a frame is in flight. They also assume that each frame is a contiguous run of strobed bytes that closes with `in_last`. The length/LG relation and the promiscuous-mode check depend on this. The stimulus changes settings only in the idle cycles between frames, and gaps inside a frame are allowed only as cycles with `in_vld` low. A scoreboard derives every accept, reject, interrupt and status word from the requirement text.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LEN_W      = 11;
  localparam int ADDR_BYTES = 6;
  localparam int WIN_BYTES  = 64;
  localparam int RSVD_W     = 32 - 8 - LEN_W;

  typedef struct packed {
    logic              m;
    logic              bc;
    logic              mc;
    logic              lg;
    logic              no;
    logic              cr;
    logic              ov;
    logic              tr;
    logic [RSVD_W-1:0] rsvd;
    logic [LEN_W-1:0]  len;
  } rx_stat_t;
endpackage

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld,
  input  logic                    last,
  input  logic [7:0]              data,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [8*ADDR_BYTES-1:0] station,
  input  logic                    promisc,
  input  logic                    mc_en,
  input  logic                    bc_rej,
  output logic                    dec_now,
  output logic                    f_valid,
  output logic                    f_pass,
  output logic                    f_bc,
  output logic                    f_mc,
  output logic                    f_m
);
  logic [7:0] sbyte;
  logic first, in_addr;
  logic uni_r, ones_r, grp_r;
  logic uni_c, ones_c, grp_c, bc_c, mc_c, norm_c, pass_c, m_c;
  logic dec_q, pass_q, bc_q, mc_q, m_q;

  always_comb begin
    sbyte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt == CNT_W'(i)) sbyte = station[8*(ADDR_BYTES-1-i) +: 8];
  end

  assign first   = (cnt == '0);
  assign in_addr = (cnt < CNT_W'(ADDR_BYTES));
  assign dec_now = vld && (cnt == CNT_W'(ADDR_BYTES-1));

  assign uni_c  = (first | uni_r)  & (data == sbyte);
  assign ones_c = (first | ones_r) & (data == 8'hFF);
  assign grp_c  = first ? data[0] : grp_r;
  assign bc_c   = ones_c;
  assign mc_c   = grp_c & ~ones_c;
  assign norm_c = uni_c | (bc_c & ~bc_rej) | (mc_c & mc_en);
  assign pass_c = norm_c | promisc;
  assign m_c    = promisc & ~norm_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      uni_r <= 1'b0; ones_r <= 1'b0; grp_r <= 1'b0;
      dec_q <= 1'b0; pass_q <= 1'b0; bc_q <= 1'b0; mc_q <= 1'b0; m_q <= 1'b0;
    end else if (vld) begin
      if (in_addr) begin
        uni_r  <= uni_c;
        ones_r <= ones_c;
        grp_r  <= grp_c;
      end
      if (last) begin
        dec_q <= 1'b0; pass_q <= 1'b0; bc_q <= 1'b0; mc_q <= 1'b0; m_q <= 1'b0;
      end else if (dec_now) begin
        dec_q <= 1'b1; pass_q <= pass_c; bc_q <= bc_c; mc_q <= mc_c; m_q <= m_c;
      end
    end
  end

  assign f_valid = dec_now | dec_q;
  assign f_pass  = dec_now ? pass_c : pass_q;
  assign f_bc    = dec_now ? bc_c   : bc_q;
  assign f_mc    = dec_now ? mc_c   : mc_q;
  assign f_m     = dec_now ? m_c    : m_q;
endmodule

// File: rtl/rxf_len_track.sv
module rxf_len_track #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             last,
  input  logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] cnt_q,
  output logic [LEN_W-1:0] new_len,
  output logic             babble_hit,
  output logic             lg_now
);
  logic babbled_q;

  assign new_len    = (cnt_q == '1) ? cnt_q : cnt_q + LEN_W'(1);
  assign babble_hit = vld && (new_len > max_len) && !babbled_q;
  assign lg_now     = babbled_q | babble_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      babbled_q <= 1'b0;
    end else if (vld) begin
      cnt_q     <= last ? '0 : new_len;
      babbled_q <= last ? 1'b0 : lg_now;
    end
  end
endmodule

// File: rtl/rxf_accept_status.sv
module rxf_accept_status
  import rxf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [7:0]              in_byte,
  input  logic                    in_last,
  input  logic                    in_dribble,
  input  logic                    in_crc_err,
  input  logic                    in_overrun,
  input  logic                    in_trunc,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [LEN_W-1:0]        max_len,
  input  logic                    promisc,
  input  logic                    mc_enable,
  input  logic                    bc_reject,
  input  logic                    babble_irq_en,
  input  logic                    frame_irq_en,
  output logic                    fifo_accept,
  output logic                    fifo_reject,
  output logic                    stat_vld,
  output logic [31:0]             stat_word,
  output logic                    babble_irq,
  output logic                    frame_irq
);
  logic [LEN_W-1:0] cnt_q, new_len;
  logic babble_hit, lg_now;
  logic dec_now, f_valid, f_pass, f_bc, f_mc, f_m, pass_eff;
  rx_stat_t st_n;

  rxf_len_track #(.LEN_W(LEN_W)) len_i (
    .clk(clk), .rst(rst), .vld(in_vld), .last(in_last), .max_len(max_len),
    .cnt_q(cnt_q), .new_len(new_len), .babble_hit(babble_hit), .lg_now(lg_now)
  );

  rxf_addr_filter #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(LEN_W)) filt_i (
    .clk(clk), .rst(rst), .vld(in_vld), .last(in_last), .data(in_byte),
    .cnt(cnt_q), .station(station_addr), .promisc(promisc),
    .mc_en(mc_enable), .bc_rej(bc_reject), .dec_now(dec_now),
    .f_valid(f_valid), .f_pass(f_pass), .f_bc(f_bc), .f_mc(f_mc), .f_m(f_m)
  );

  assign pass_eff = !f_valid || f_pass;

  always_comb begin
    st_n      = '0;
    st_n.m    = f_m;
    st_n.bc   = f_bc;
    st_n.mc   = f_mc;
    st_n.lg   = lg_now;
    st_n.no   = in_dribble;
    st_n.cr   = in_crc_err;
    st_n.ov   = in_overrun;
    st_n.tr   = in_trunc;
    st_n.len  = new_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_accept <= 1'b0;
      fifo_reject <= 1'b0;
      stat_vld    <= 1'b0;
      stat_word   <= '0;
      babble_irq  <= 1'b0;
      frame_irq   <= 1'b0;
    end else begin
      fifo_accept <= 1'b0;
      fifo_reject <= 1'b0;
      stat_vld    <= 1'b0;
      babble_irq  <= 1'b0;
      frame_irq   <= 1'b0;
      if (in_vld) begin
        if (dec_now && !f_pass)
          fifo_reject <= 1'b1;
        if (new_len == LEN_W'(WIN_BYTES) && f_valid && f_pass)
          fifo_accept <= 1'b1;
        if (in_last && new_len < LEN_W'(WIN_BYTES) && pass_eff)
          fifo_reject <= 1'b1;
        if (babble_hit && babble_irq_en)
          babble_irq <= 1'b1;
        if (in_last) begin
          stat_vld  <= 1'b1;
          stat_word <= st_n;
          frame_irq <= frame_irq_en;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_accept_status_chk.sv
module rxf_accept_status_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             promisc,
  input logic             babble_irq_en,
  input logic             frame_irq_en,
  input logic [LEN_W-1:0] max_len,
  input logic             fifo_accept,
  input logic             fifo_reject,
  input logic             stat_vld,
  input logic [31:0]      stat_word,
  input logic             babble_irq,
  input logic             frame_irq
);
  // R4
  accept_reject_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_accept && fifo_reject));
  // R4
  accept_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_accept |-> $past(in_vld));
  // R9
  babble_masked_chk: assert property (@(posedge clk) disable iff (rst)
    babble_irq |-> ($past(in_vld) && $past(babble_irq_en)));
  // R9
  lg_matches_len_chk: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> (stat_word[28] == (stat_word[LEN_W-1:0] > max_len)));
  // R11
  frame_irq_with_stat_chk: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> (stat_vld && $past(frame_irq_en)));
  // R7
  bc_mc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> !(stat_word[30] && stat_word[29]));
  // R8
  m_needs_promisc_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_vld && stat_word[31]) |-> $past(promisc));
  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> (stat_word[23:LEN_W] == '0));
endmodule

bind rxf_accept_status rxf_accept_status_chk #(.LEN_W(rxf_pkg::LEN_W)) chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .promisc(promisc),
  .babble_irq_en(babble_irq_en), .frame_irq_en(frame_irq_en), .max_len(max_len),
  .fifo_accept(fifo_accept), .fifo_reject(fifo_reject), .stat_vld(stat_vld),
  .stat_word(stat_word), .babble_irq(babble_irq), .frame_irq(frame_irq)
);

// File: tb/rxf_accept_status_tb_top.sv
`timescale 1ns/1ps
module rxf_accept_status_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_dribble = 1'b0, in_crc_err = 1'b0, in_overrun = 1'b0, in_trunc = 1'b0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic [10:0] max_len = 11'd1518;
  logic promisc = 1'b0, mc_enable = 1'b0, bc_reject = 1'b0;
  logic babble_irq_en = 1'b1, frame_irq_en = 1'b1;
  logic fifo_accept, fifo_reject, stat_vld, babble_irq, frame_irq;
  logic [31:0] stat_word;

  typedef struct {
    int          kind;   // 0 accept, 1 reject, 2 babble, 3 status, 4 frame irq
    logic [31:0] val;
    string       tag;
  } ev_t;
  ev_t sb_q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxf_accept_status dut_i (.*);

  task automatic push(input int k, input logic [31:0] v, input string t);
    ev_t e;
    e.kind = k; e.val = v; e.tag = t;
    sb_q.push_back(e);
  endtask

  task automatic mon_one(input int k, input logic hit, input logic [31:0] v);
    if (hit) begin
      vectors++;
      if (sb_q.size() == 0 || sb_q[0].kind != k) begin
        miscompares++;
        $display("FAIL %s: unexpected output kind %0d (actual pulse, expected kind %0d)",
                 (sb_q.size() == 0) ? "R4" : sb_q[0].tag, k,
                 (sb_q.size() == 0) ? -1 : sb_q[0].kind);
      end else begin
        if (k == 3 && v !== sb_q[0].val) begin
          miscompares++;
          $display("FAIL %s: status actual %h expected %h", sb_q[0].tag, v, sb_q[0].val);
        end
        void'(sb_q.pop_front());
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      mon_one(0, fifo_accept, 32'd0);
      mon_one(1, fifo_reject, 32'd0);
      mon_one(2, babble_irq, 32'd0);
      mon_one(3, stat_vld, stat_word);
      mon_one(4, frame_irq, 32'd0);
    end
  end

  // err = {dribble, crc, overrun, trunc}
  task automatic run_frame(input logic [47:0] dst, input int n, input logic [3:0] err,
                           input string tag);
    logic uni, bc, mc, norm, pass, m, bab, dec;
    logic [10:0] len;
    uni  = (dst == station_addr);
    bc   = (dst == 48'hFFFF_FFFF_FFFF);
    mc   = dst[40] && !bc;
    norm = uni || (bc && !bc_reject) || (mc && mc_enable);
    pass = norm || promisc;
    m    = promisc && !norm;
    dec  = (n >= 6);
    bab  = 1'b0;
    for (int i = 0; i < n; i++) begin
      len = (i + 1 > 2047) ? 11'd2047 : 11'(i + 1);
      if (len == 11'd64 && dec && pass) push(0, 0, "R4");
      if (i == 5 && !pass) push(1, 0, "R3");
      if (i == n - 1 && len < 11'd64 && (!dec || pass)) push(1, 0, "R5");
      if (len > max_len && !bab) begin
        bab = 1'b1;
        if (babble_irq_en) push(2, 0, "R9");
      end
      if (i == n - 1) begin
        push(3, {dec && m, dec && bc, dec && mc, bab, err, 13'd0, len}, tag);
        if (frame_irq_en) push(4, 0, "R11");
      end
      in_vld  = 1'b1;
      in_byte = (i < 6) ? dst[47 - 8*i -: 8] : 8'(i * 7 + 3);
      in_last = (i == n - 1);
      {in_dribble, in_crc_err, in_overrun, in_trunc} = (i == n - 1) ? err : 4'b0;
      @(posedge clk); #1;
    end
    in_vld = 1'b0; in_last = 1'b0;
    {in_dribble, in_crc_err, in_overrun, in_trunc} = 4'b0;
    repeat (3) @(posedge clk); #1;
    vectors++;
    if (sb_q.size() != 0) begin
      miscompares++;
      $display("FAIL %s: %0d expected outputs missing (actual remaining %0d, expected 0)",
               tag, sb_q.size(), sb_q.size());
      sb_q.delete();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if ({fifo_accept, fifo_reject, stat_vld, babble_irq, frame_irq} !== 5'b0 || stat_word !== '0) begin
      miscompares++;
      $display("FAIL R1: outputs actual %b/%h expected 0/0",
               {fifo_accept, fifo_reject, stat_vld, babble_irq, frame_irq}, stat_word);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    run_frame(48'h02_11_22_33_44_55, 70, 4'b0000, "R2");        // unicast hit
    run_frame(48'h02_11_22_33_44_56, 70, 4'b0000, "R3");        // unicast miss
    run_frame(48'hFFFF_FFFF_FFFF, 64, 4'b0000, "R7");           // broadcast, exact window
    bc_reject = 1'b1;
    run_frame(48'hFFFF_FFFF_FFFF, 80, 4'b0000, "R2");           // broadcast refused
    bc_reject = 1'b0;
    mc_enable = 1'b1;
    run_frame(48'h01_00_5E_00_00_01, 90, 4'b0000, "R7");        // multicast pass
    mc_enable = 1'b0;
    run_frame(48'h01_00_5E_00_00_01, 90, 4'b0000, "R2");        // multicast refused
    promisc = 1'b1;
    run_frame(48'h0A_BB_CC_DD_EE_FF, 66, 4'b0000, "R8");        // promiscuous pass
    run_frame(48'h02_11_22_33_44_55, 66, 4'b0000, "R8");        // promisc, no M
    promisc = 1'b0;
    run_frame(48'h02_11_22_33_44_55, 40, 4'b0000, "R5");        // runt
    run_frame(48'h02_11_22_33_44_55, 6, 4'b0000, "R5");         // ends at address
    run_frame(48'h0A_11_22_33_44_55, 6, 4'b0000, "R3");         // fails at address end
    run_frame(48'hFFFF_FFFF_FFFF, 4, 4'b0000, "R7");            // shorter than address
    max_len = 11'd100;
    run_frame(48'h02_11_22_33_44_55, 150, 4'b0000, "R9");       // babble
    babble_irq_en = 1'b0;
    run_frame(48'h02_11_22_33_44_55, 101, 4'b0000, "R9");       // LG, irq masked
    run_frame(48'h02_11_22_33_44_55, 100, 4'b0000, "R9");       // at limit
    babble_irq_en = 1'b1;
    max_len = 11'd1518;
    run_frame(48'h02_11_22_33_44_55, 70, 4'b1010, "R10");
    run_frame(48'h02_11_22_33_44_55, 70, 4'b0101, "R10");
    frame_irq_en = 1'b0;
    run_frame(48'h02_11_22_33_44_55, 70, 4'b0000, "R11");
    frame_irq_en = 1'b1;
    max_len = 11'd2047;
    run_frame(48'h02_11_22_33_44_55, 2100, 4'b0000, "R12");     // saturation
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end
endmodule